// File: doc/BRIEF.md
# Dual Byte Queue with Threshold Flags

This block holds two byte queues for a serial bus master, each eight entries deep. The transmit queue is filled by the processor and drained by the bus engine. The receive queue is filled by the bus engine and drained by the processor. Both processor directions share one data address. A write there appends to the transmit queue, and a read there removes the oldest received byte.

A control register sets a threshold for each queue and can empty either queue. It uses one self-clearing bit per queue. Three sticky flags report three conditions: transmit occupancy has fallen to its threshold, receive occupancy has reached its threshold, and the bus engine finished a byte while the transmit queue was empty. Each flag has its own enable bit, and the enabled flags are ORed into one interrupt line. Both occupancy counts can be read at their own addresses.

Register addresses on `reg_addr_i`: 0 data, 1 control, 2 flags, 3 enables, 4 receive count, 5 transmit count. Reads return their value combinationally in the same cycle. Writes take effect at the clock edge.

Top module: `byte_fifo_pair`

## Requirements
- R1: Each queue holds at most 8 bytes. Address 4 reads the receive count and address 5 reads the transmit count, both zero-extended to 8 bits.
- R2: A write to address 0 appends `reg_wdata_i` to the transmit queue. When the queue already holds 8 bytes, the write is dropped and the count stays at 8.
- R3: A read of address 0 returns the oldest receive byte and removes it. When the receive queue is empty, the read returns 0 and the count stays 0.
- R4: `tx_data_o` shows the oldest transmit byte and `tx_pop_i` removes it. `rx_push_i` appends `rx_data_i`. A push to a full receive queue is dropped, and a pop from an empty transmit queue does nothing.
- R5: Control register (address 1) layout. Writing bit 0 as 1 empties the transmit queue and writing bit 1 as 1 empties the receive queue, so the count reads 0 in the next cycle. Bits 1:0 always read 0. Bits 7:2 are stored and read back.
- R6: Control bits 3:2 hold the transmit threshold code: 0 means empty, 1 means at most 1 byte, 2 means at most 2 bytes, 3 means at most 4 bytes. Flag bit 0 sets on the clock edge at which the transmit count is at or below that threshold.
- R7: Control bits 7:4 hold a level L. Flag bit 1 sets on the clock edge at which the receive count is at least L+1.
- R8: Flag bit 2 sets on the clock edge at which `tx_sent_i` is high while the transmit queue is empty.
- R9: Flags (address 2) are sticky. Writing a 0 to a flag bit clears it and writing a 1 leaves it unchanged. A set condition in the same cycle wins over the clear.
- R10: Enables (address 3) bits 2:0 match flag bits 2:0. `irq_o` is high while any flag and its enable are both set.
- R11: While reset is asserted and right after it, both counts, the flags, the enables and the control fields are 0, `irq_o` is 0, `tx_avail_o` is 0 and `rx_room_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on address 0) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| tx_pop_i | input | 1 | Bus side removes the transmit head |
| tx_data_o | output | 8 | Transmit head byte |
| tx_avail_o | output | 1 | Transmit queue not empty |
| tx_sent_i | input | 1 | Bus side finished shifting a byte |
| rx_push_i | input | 1 | Bus side appends a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_room_o | output | 1 | Receive queue not full |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong pointer or count shows within one access. A read of the data port returns bytes out of order, or a count register shows a value that the bench's own tally contradicts. A wrong threshold decode shows one edge after the count crosses the boundary, when the flag register has the bit set or clear against expectation. A flag-clear or enable error shows as a wrong `irq_o` in the cycle after the write.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
  localparam int ADDR_W = 3;
  localparam int REG_W  = 8;
  localparam int FLAG_N = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 3'd0,
    A_CTRL  = 3'd1,
    A_FLAG  = 3'd2,
    A_IEN   = 3'd3,
    A_RXCNT = 3'd4,
    A_TXCNT = 3'd5
  } reg_addr_e;

  // transmit threshold code -> max occupancy that fires
  function automatic logic [3:0] tx_thr(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd0;
      2'd1:    return 4'd1;
      2'd2:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     data_i,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wr_ptr] <= data_i;
  end

  assign data_o  = empty_o ? '0 : mem[rd_ptr];
  assign count_o = cnt;
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;  // set beats clear
      else if (wr_i)     q[i] <= q[i] & keep_i[i];
    end
  end

  assign flags_o = q;
endmodule

// File: rtl/byte_fifo_pair.sv
module byte_fifo_pair
  import fifo_pair_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              tx_pop_i,
  output logic [REG_W-1:0]  tx_data_o,
  output logic              tx_avail_o,
  input  logic              tx_sent_i,
  input  logic              rx_push_i,
  input  logic [REG_W-1:0]  rx_data_i,
  output logic              rx_room_o,
  output logic              irq_o
);
  logic             wr_data, rd_data, wr_ctrl, wr_flag, wr_ien;
  logic             flush_tx, flush_rx;
  logic [1:0]       tx_code_q;
  logic [3:0]       rx_lvl_q;
  logic [FLAG_N-1:0] ien_q, flag_q, flag_set;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [REG_W-1:0] rx_head;

  assign wr_data = reg_we_i && (reg_addr_i == A_DATA);
  assign rd_data = reg_re_i && (reg_addr_i == A_DATA);
  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_flag = reg_we_i && (reg_addr_i == A_FLAG);
  assign wr_ien  = reg_we_i && (reg_addr_i == A_IEN);

  // reset bits act on the write edge and are never stored
  assign flush_tx = wr_ctrl && reg_wdata_i[0];
  assign flush_rx = wr_ctrl && reg_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_code_q <= '0;
      rx_lvl_q  <= '0;
      ien_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_code_q <= reg_wdata_i[3:2];
        rx_lvl_q  <= reg_wdata_i[7:4];
      end
      if (wr_ien) ien_q <= reg_wdata_i[FLAG_N-1:0];
    end
  end

  byte_fifo #(.DEPTH(DEPTH), .W(REG_W)) u_tx (
    .clk_i, .rst_ni,
    .flush_i(flush_tx), .push_i(wr_data), .pop_i(tx_pop_i),
    .data_i(reg_wdata_i), .data_o(tx_data_o),
    .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  byte_fifo #(.DEPTH(DEPTH), .W(REG_W)) u_rx (
    .clk_i, .rst_ni,
    .flush_i(flush_rx), .push_i(rx_push_i), .pop_i(rd_data),
    .data_i(rx_data_i), .data_o(rx_head),
    .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  assign flag_set[0] = 32'(tx_cnt) <= 32'(tx_thr(tx_code_q));
  assign flag_set[1] = 32'(rx_cnt) >= 32'(rx_lvl_q) + 32'd1;
  assign flag_set[2] = tx_sent_i && tx_empty;

  sticky_flags #(.N(FLAG_N)) u_flags (
    .clk_i, .rst_ni,
    .set_i(flag_set), .wr_i(wr_flag),
    .keep_i(reg_wdata_i[FLAG_N-1:0]), .flags_o(flag_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_DATA:  reg_rdata_o = rx_head;
      A_CTRL:  reg_rdata_o = {rx_lvl_q, tx_code_q, 2'b00};
      A_FLAG:  reg_rdata_o = REG_W'(flag_q);
      A_IEN:   reg_rdata_o = REG_W'(ien_q);
      A_RXCNT: reg_rdata_o = REG_W'(rx_cnt);
      A_TXCNT: reg_rdata_o = REG_W'(tx_cnt);
      default: reg_rdata_o = '0;
    endcase
  end

  assign tx_avail_o = !tx_empty;
  assign rx_room_o  = !rx_full;
  assign irq_o      = |(flag_q & ien_q);

  logic unused_ok;
  assign unused_ok = tx_full ^ rx_empty;
endmodule

// File: rtl/byte_fifo_pair_chk.sv
module byte_fifo_pair_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic             reg_re_i,
  input logic [2:0]       reg_addr_i,
  input logic [7:0]       reg_wdata_i,
  input logic [7:0]       reg_rdata_o,
  input logic             tx_pop_i,
  input logic             tx_sent_i,
  input logic             rx_push_i,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [3:0]       rx_lvl_q,
  input logic [2:0]       flag_q
);
  p_tx_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tx_cnt) <= DEPTH);
  p_rx_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(rx_cnt) <= DEPTH);
  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd0 && tx_cnt == CNT_W'(DEPTH) && !tx_pop_i
     && !(reg_we_i && reg_addr_i == 3'd1 && reg_wdata_i[0]))
    |=> tx_cnt == CNT_W'(DEPTH));
  p_empty_read_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == 3'd0 && rx_cnt == '0) |-> reg_rdata_o == 8'd0);
  p_empty_read_stay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == 3'd0 && rx_cnt == '0 && !rx_push_i) |=> rx_cnt == '0);
  p_tx_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd1 && reg_wdata_i[0]) |=> tx_cnt == '0);
  p_rx_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd1 && reg_wdata_i[1]) |=> rx_cnt == '0);
  p_rx_trig_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(rx_cnt) >= 32'(rx_lvl_q) + 32'd1) |=> flag_q[1]);
  p_tend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_sent_i && tx_cnt == '0) |=> flag_q[2]);
endmodule

bind byte_fifo_pair byte_fifo_pair_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .tx_pop_i(tx_pop_i), .tx_sent_i(tx_sent_i), .rx_push_i(rx_push_i),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_lvl_q(rx_lvl_q), .flag_q(flag_q)
);

// File: tb/byte_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module byte_fifo_pair_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       tx_pop_i = 1'b0;
  logic [7:0] tx_data_o;
  logic       tx_avail_o;
  logic       tx_sent_i = 1'b0;
  logic       rx_push_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_room_o;
  logic       irq_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  byte_fifo_pair dut_i (.*);

  typedef struct packed {
    logic [1:0] op;    // 0 write, 1 read-check, 2 tx pop-check, 3 rx push
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd1, 8'h27, 8'h00, 4'd5},  // R5 ctrl: tx code 1, rx level 2, reset bits
    '{2'd1, 3'd1, 8'h00, 8'h24, 4'd5},  // R5 reset bits read 0
    '{2'd0, 3'd0, 8'hA1, 8'h00, 4'd2},
    '{2'd0, 3'd0, 8'hB2, 8'h00, 4'd2},
    '{2'd0, 3'd0, 8'hC3, 8'h00, 4'd2},
    '{2'd1, 3'd5, 8'h00, 8'h03, 4'd2},  // R2 tx count
    '{2'd0, 3'd2, 8'h00, 8'h00, 4'd9},
    '{2'd1, 3'd2, 8'h00, 8'h00, 4'd9},  // R9 cleared
    '{2'd2, 3'd0, 8'h00, 8'hA1, 4'd4},  // R4 head order
    '{2'd2, 3'd0, 8'h00, 8'hB2, 4'd4},
    '{2'd1, 3'd5, 8'h00, 8'h01, 4'd4},
    '{2'd1, 3'd2, 8'h00, 8'h01, 4'd6},  // R6 code 1 fires at 1
    '{2'd3, 3'd0, 8'h11, 8'h00, 4'd4},
    '{2'd3, 3'd0, 8'h22, 8'h00, 4'd4},
    '{2'd1, 3'd2, 8'h00, 8'h01, 4'd7},  // R7 two below level+1
    '{2'd3, 3'd0, 8'h33, 8'h00, 4'd4},
    '{2'd1, 3'd4, 8'h00, 8'h03, 4'd1},  // R1 rx count
    '{2'd1, 3'd2, 8'h00, 8'h03, 4'd7},  // R7 reached
    '{2'd1, 3'd0, 8'h00, 8'h11, 4'd3},  // R3 order
    '{2'd1, 3'd0, 8'h00, 8'h22, 4'd3},
    '{2'd1, 3'd0, 8'h00, 8'h33, 4'd3},
    '{2'd1, 3'd0, 8'h00, 8'h00, 4'd3},  // R3 empty read
    '{2'd1, 3'd4, 8'h00, 8'h00, 4'd3},
    '{2'd0, 3'd2, 8'h01, 8'h00, 4'd9},
    '{2'd1, 3'd2, 8'h00, 8'h01, 4'd9},  // R9 write-1 keeps
    '{2'd2, 3'd0, 8'h00, 8'hC3, 4'd4},
    '{2'd0, 3'd3, 8'h04, 8'h00, 4'd10}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1 reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 check(req, reg_rdata_o, exp);
    @(posedge clk_i); #1 reg_re_i = 1'b0;
  endtask

  task automatic pop(input logic [7:0] exp, input string req);
    @(negedge clk_i);
    tx_pop_i = 1'b1;
    #1 check(req, tx_data_o, exp);
    @(posedge clk_i); #1 tx_pop_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk_i);
    rx_push_i = 1'b1; rx_data_i = d;
    @(posedge clk_i); #1 rx_push_i = 1'b0;
  endtask

  task automatic sent();
    @(negedge clk_i);
    tx_sent_i = 1'b1;
    @(posedge clk_i); #1 tx_sent_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R11 reset state
    #3;
    reg_addr_i = 3'd2; #1 check("R11 flags", reg_rdata_o, 8'h00);
    reg_addr_i = 3'd4; #1 check("R11 rxcnt", reg_rdata_o, 8'h00);
    reg_addr_i = 3'd5; #1 check("R11 txcnt", reg_rdata_o, 8'h00);
    reg_addr_i = 3'd1; #1 check("R11 ctrl", reg_rdata_o, 8'h00);
    check("R11 irq", {7'd0, irq_o}, 8'h00);
    check("R11 avail", {7'd0, tx_avail_o}, 8'h00);
    check("R11 room", {7'd0, rx_room_o}, 8'h01);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      case (VECS[i].op)
        2'd0: wr(VECS[i].addr, VECS[i].data);
        2'd1: rd(VECS[i].addr, VECS[i].exp, tag);
        2'd2: pop(VECS[i].exp, tag);
        default: push(VECS[i].data);
      endcase
    end

    // R8 / R10: transmit end while empty, enable bit 2 set
    sent();
    rd(3'd2, 8'h05, "R8 tend set");
    check("R10 irq on", {7'd0, irq_o}, 8'h01);
    wr(3'd2, 8'h01);
    rd(3'd2, 8'h01, "R9 tend cleared");
    check("R10 irq off", {7'd0, irq_o}, 8'h00);
    wr(3'd0, 8'h55);
    sent();
    rd(3'd2, 8'h01, "R8 no tend when not empty");

    // R2 overflow: one queued plus eight more, last is dropped
    for (int i = 0; i < 8; i++) wr(3'd0, 8'h60 + 8'(i));
    rd(3'd5, 8'h08, "R2 full count");
    check("R4 avail", {7'd0, tx_avail_o}, 8'h01);
    pop(8'h55, "R2 order");
    for (int i = 0; i < 7; i++) pop(8'h60 + 8'(i), "R2 order");
    rd(3'd5, 8'h00, "R2 dropped byte absent");
    pop(8'h00, "R4 pop empty");
    rd(3'd5, 8'h00, "R4 pop empty count");

    // R4 receive overflow, R5 receive flush
    for (int i = 0; i < 9; i++) push(8'h80 + 8'(i));
    rd(3'd4, 8'h08, "R4 rx full count");
    check("R4 room", {7'd0, rx_room_o}, 8'h00);
    rd(3'd0, 8'h80, "R4 rx head");
    rd(3'd4, 8'h07, "R1 rx count");
    wr(3'd1, 8'h26);
    rd(3'd4, 8'h00, "R5 rx flush");
    rd(3'd1, 8'h24, "R5 ctrl readback");

    // R6 code 3 fires at four or fewer
    wr(3'd1, 8'h0C);
    for (int i = 0; i < 5; i++) wr(3'd0, 8'h40 + 8'(i));
    wr(3'd2, 8'h00);
    rd(3'd2, 8'h00, "R6 five above code3");
    pop(8'h40, "R6 head");
    rd(3'd5, 8'h04, "R6 count");
    rd(3'd2, 8'h01, "R6 four fires code3");
    wr(3'd1, 8'h0D);
    rd(3'd5, 8'h00, "R5 tx flush");
    check("R5 avail", {7'd0, tx_avail_o}, 8'h00);

    // R7 level 0, R9 set wins, R10 receive irq
    wr(3'd3, 8'h02);
    push(8'h99);
    rd(3'd4, 8'h01, "R7 count");
    rd(3'd2, 8'h03, "R7 level0 fires at 1");
    check("R10 rx irq", {7'd0, irq_o}, 8'h01);
    wr(3'd2, 8'h01);
    rd(3'd2, 8'h03, "R9 set wins over clear");

    done = 1;
    finish_run();
  end
endmodule